// File: doc/BRIEF.md
# Bidirectional Port with Direction Register

This block is an eight-line general-purpose pin port for a small microcontroller register file. Software sets the direction of each line through a direction register that can be written but not read back. It writes the output levels through a data register. A read of the data address returns the live pin levels for lines set as inputs and the stored output level for lines set as outputs. The pads are modelled as three vectors per line: output enable, output level, and the level sampled from the pin. A fourth vector says whether anything outside drives the pin.

One global input selects how every output line drives its pad. In push-pull drive, the pad follows the data bit. In open-drain drive, the pad is pulled low for a 0 and released for a 1. Each input line can hold the last level it saw while driven, so a pin left floating keeps reading that level. Incoming levels pass through a two-stage synchronizer before software or the serial engine can see them.

While the serial-interface enable is high, line 0 becomes the serial data input and line 7 becomes the serial data output. This holds whatever the direction register contains. When the enable drops, the direction register takes control again.

Top module: `pio_port`

## Requirements
- R1: After reset every line is an input: `pad_oe` and `pad_o` are all zero, the data register holds 0, and a read of the data address returns the synchronized pin levels.
- R2: A write to address 0xF6 loads the direction register, one bit per line. A 1 makes that line an input and a 0 makes it an output. Each line follows only its own bit.
- R3: The direction register cannot be read. A read of 0xF6, or of any address other than the data address 0x02, returns 0.
- R4: A line set as input never drives its pad: its `pad_oe` bit is 0.
- R5: With `open_drain` low, an output line has `pad_oe` at 1 and `pad_o` equal to its data bit.
- R6: With `open_drain` high, an output line whose data bit is 0 has `pad_oe` at 1 and `pad_o` at 0. An output line whose data bit is 1 has `pad_oe` at 0. `pad_o` is never 1 while that line's `pad_oe` is 1.
- R7: A read of the data address 0x02 returns, bit by bit, the synchronized pin level for input lines and the data register bit for output lines. Data register writes go to address 0x02.
- R8: A pin change reaches the read data after the second rising clock edge, and not after the first.
- R9: While a line's `pad_valid` bit is 0, that line reads the last level sampled while it was valid. The level is 0 if the line has never been valid since reset.
- R10: While `spi_en` is high, line 0 is an input regardless of the direction register, and `spi_di` equals line 0's synchronized level. While `spi_en` is low, `spi_di` is 0.
- R11: While `spi_en` is high, line 7 is an output driven from `spi_do` under the global drive mode, regardless of the direction register. It reads back as data register bit 7.
- R12: Dropping `spi_en` returns lines 0 and 7 to the direction register contents written earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for writes and reads |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| open_drain | input | 1 | Global drive mode: 1 = open-drain, 0 = push-pull |
| spi_en | input | 1 | Serial interface enable, takes over lines 0 and 7 |
| spi_do | input | 1 | Serial data to drive on line 7 |
| spi_di | output | 1 | Synchronized serial data from line 0 |
| pad_in | input | 8 | Level sampled at each pin |
| pad_valid | input | 8 | 1 where something outside drives the pin |
| pad_oe | output | 8 | Pad output enable per line |
| pad_o | output | 8 | Pad output level per line |

## Verification
The bench builds the port with its default parameters: eight lines, the level-hold keeper present, and the serial lines at positions 0 and 7. This configuration is small enough that all 256 direction patterns can be swept. Each pattern is paired with a derived data value, both drive modes and both serial-enable states, and the expected pad and read vectors are computed arithmetically for every combination. Directed sequences then cover the two-edge synchronizer latency, the floating-pin hold on full and partial `pad_valid` masks, and the return of direction-register control when the serial enable drops.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic {
        DRV_PUSH_PULL  = 1'b0,
        DRV_OPEN_DRAIN = 1'b1
    } drive_e;

    function automatic drive_e drive_of(input logic od_bit);
        return od_bit ? DRV_OPEN_DRAIN : DRV_PUSH_PULL;
    endfunction

endpackage

// File: rtl/pio_regs.sv
module pio_regs #(
    parameter int              W         = 8,
    parameter int              AW        = 8,
    parameter logic [AW-1:0]   MODE_ADDR = 8'hF6,
    parameter logic [AW-1:0]   DATA_ADDR = 8'h02
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  mode_q,
    output logic [W-1:0]  dout_q
);

    logic hit_mode;
    logic hit_data;

    assign hit_mode = wr_en && (addr == MODE_ADDR);
    assign hit_data = wr_en && (addr == DATA_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '1;
            dout_q <= '0;
        end else begin
            if (hit_mode) mode_q <= wdata;
            if (hit_data) dout_q <= wdata;
        end
    end

    AST_MODE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == MODE_ADDR) |=> (mode_q == $past(wdata))); // R2

    AST_DATA_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == DATA_ADDR) |=> $stable(dout_q)); // R7

endmodule

// File: rtl/pio_insync.sv
module pio_insync #(
    parameter int W      = 8,
    parameter bit KEEPER = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] pad_valid,
    output logic [W-1:0] sync_q
);

    logic [W-1:0] level;
    logic [W-1:0] stage1_q;

    for (genvar i = 0; i < W; i++) begin : g_line
        if (KEEPER) begin : g_keep
            logic hold_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            hold_q <= 1'b0;
                else if (pad_valid[i]) hold_q <= pad_in[i];
            end
            assign level[i] = pad_valid[i] ? pad_in[i] : hold_q;
        end else begin : g_nokeep
            assign level[i] = pad_valid[i] & pad_in[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            sync_q   <= '0;
        end else begin
            stage1_q <= level;
            sync_q   <= stage1_q;
        end
    end

    AST_FLOAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_valid == '0 && $past(pad_valid) == '0 && $past(pad_valid, 2) == '0)
            |-> $stable(sync_q)); // R9

endmodule

// File: rtl/pio_drive.sv
module pio_drive
    import pio_pkg::*;
#(
    parameter int W      = 8,
    parameter int DI_BIT = 0,
    parameter int DO_BIT = 7
) (
    input  logic         open_drain,
    input  logic         spi_en,
    input  logic         spi_do,
    input  logic [W-1:0] mode_q,
    input  logic [W-1:0] dout_q,
    output logic [W-1:0] dir_in,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_o
);

    drive_e       drv;
    logic [W-1:0] src;

    assign drv = drive_of(open_drain);

    always_comb begin
        dir_in = mode_q;
        src    = dout_q;
        if (spi_en) begin
            dir_in[DI_BIT] = 1'b1;
            dir_in[DO_BIT] = 1'b0;
            src[DO_BIT]    = spi_do;
        end
    end

    always_comb begin
        unique case (drv)
            DRV_PUSH_PULL: begin
                pad_oe = ~dir_in;
                pad_o  = src & ~dir_in;
            end
            DRV_OPEN_DRAIN: begin
                pad_oe = ~dir_in & ~src;
                pad_o  = '0;
            end
            default: begin
                pad_oe = '0;
                pad_o  = '0;
            end
        endcase
    end

endmodule

// File: rtl/pio_port.sv
module pio_port #(
    parameter int              W         = 8,
    parameter int              AW        = 8,
    parameter logic [AW-1:0]   MODE_ADDR = 8'hF6,
    parameter logic [AW-1:0]   DATA_ADDR = 8'h02,
    parameter int              DI_BIT    = 0,
    parameter int              DO_BIT    = 7,
    parameter bit              KEEPER    = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rd_data,
    input  logic          open_drain,
    input  logic          spi_en,
    input  logic          spi_do,
    output logic          spi_di,
    input  logic [W-1:0]  pad_in,
    input  logic [W-1:0]  pad_valid,
    output logic [W-1:0]  pad_oe,
    output logic [W-1:0]  pad_o
);

    logic [W-1:0] mode_q;
    logic [W-1:0] dout_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] dir_in;

    pio_regs #(.W(W), .AW(AW), .MODE_ADDR(MODE_ADDR), .DATA_ADDR(DATA_ADDR)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .mode_q (mode_q),
        .dout_q (dout_q)
    );

    pio_insync #(.W(W), .KEEPER(KEEPER)) u_insync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_in    (pad_in),
        .pad_valid (pad_valid),
        .sync_q    (sync_q)
    );

    pio_drive #(.W(W), .DI_BIT(DI_BIT), .DO_BIT(DO_BIT)) u_drive (
        .open_drain (open_drain),
        .spi_en     (spi_en),
        .spi_do     (spi_do),
        .mode_q     (mode_q),
        .dout_q     (dout_q),
        .dir_in     (dir_in),
        .pad_oe     (pad_oe),
        .pad_o      (pad_o)
    );

    // Direction register is write-only: only the data address returns anything.
    assign rd_data = (addr == DATA_ADDR) ? ((dir_in & sync_q) | (~dir_in & dout_q)) : '0;
    assign spi_di  = spi_en & sync_q[DI_BIT];

    AST_RESET_QUIET: assert property (@(posedge clk)
        $rose(rst_n) |-> (pad_oe == '0)); // R1

    AST_MODE_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != DATA_ADDR) |-> (rd_data == '0)); // R3

    AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == MODE_ADDR && !spi_en)
            |=> (spi_en || ((pad_oe & $past(wdata)) == '0))); // R4

    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        open_drain |-> ((pad_oe & pad_o) == '0)); // R6

    AST_SPI_DI_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        spi_en |-> !pad_oe[DI_BIT]); // R10

    AST_SPI_DI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_en |-> !spi_di); // R10

    AST_SPI_DO_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && !open_drain) |-> (pad_oe[DO_BIT] && pad_o[DO_BIT] == spi_do)); // R11

endmodule

// File: tb/pio_port_bench.sv
module pio_port_bench;

    localparam time TCLK = 8ns;
    localparam logic [7:0] A_MODE = 8'hF6;
    localparam logic [7:0] A_DATA = 8'h02;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = A_DATA;
    logic [7:0] wdata = '0;
    logic [7:0] rd_data;
    logic       open_drain = 1'b0;
    logic       spi_en = 1'b0;
    logic       spi_do = 1'b0;
    logic       spi_di;
    logic [7:0] pad_in = 8'h3C;
    logic [7:0] pad_valid = 8'hFF;
    logic [7:0] pad_oe;
    logic [7:0] pad_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(TCLK/2) clk = ~clk;

    pio_port u_pio_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .open_drain(open_drain), .spi_en(spi_en),
        .spi_do(spi_do), .spi_di(spi_di), .pad_in(pad_in),
        .pad_valid(pad_valid), .pad_oe(pad_oe), .pad_o(pad_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = A_DATA;
    endtask

    task automatic settle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(TCLK * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d, din, src, exp_oe, exp_o, exp_rd, pins;
        settle(2);
        chk("R1 oe in reset", pad_oe, 8'h00);
        chk("R1 o in reset", pad_o, 8'h00);
        rst_n = 1'b1;
        settle(3);
        addr = A_DATA; #1;
        chk("R1 read pins after reset", rd_data, 8'h3C);
        chk("R1 oe after reset", pad_oe, 8'h00);
        addr = A_MODE; #1;
        chk("R3 mode read hidden", rd_data, 8'h00);
        addr = 8'h55; #1;
        chk("R3 other addr zero", rd_data, 8'h00);
        addr = A_DATA;

        // full sweep of direction patterns
        pins = 8'h96;
        pad_in = pins;
        settle(3);
        for (int m = 0; m < 256; m++) begin
            d = 8'((m * 37 + 11) & 8'hFF);
            reg_write(A_MODE, 8'(m));
            reg_write(A_DATA, d);
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                open_drain = c[0];
                spi_en     = c[1];
                spi_do     = m[3] ^ c[0];
                addr       = A_DATA;
                #1;
                din = 8'(m);
                src = d;
                if (spi_en) begin
                    din = (din | 8'h01) & 8'h7F;
                    src = {spi_do, d[6:0]};
                end
                if (open_drain) begin
                    exp_oe = ~din & ~src;
                    exp_o  = 8'h00;
                end else begin
                    exp_oe = ~din;
                    exp_o  = src & ~din;
                end
                exp_rd = (din & pins) | (~din & d);
                chk(spi_en ? (open_drain ? "R6/R10/R11 oe" : "R5/R10/R11 oe")
                           : (open_drain ? "R2/R4/R6 oe" : "R2/R4/R5 oe"), pad_oe, exp_oe);
                chk(open_drain ? "R6 o" : "R5 o", pad_o, exp_o);
                chk("R7 read", rd_data, exp_rd);
                chk("R10 spi_di", {7'd0, spi_di}, spi_en ? {7'd0, pins[0]} : 8'h00);
            end
        end
        @(negedge clk);
        spi_en = 1'b0; open_drain = 1'b0;

        // synchronizer latency
        reg_write(A_MODE, 8'hFF);
        @(negedge clk);
        pad_in = 8'h5A;
        @(negedge clk); #1;
        chk("R8 not after one edge", rd_data, 8'h96);
        @(negedge clk); #1;
        chk("R8 visible after two edges", rd_data, 8'h5A);

        // floating pins hold their last level
        pad_in = 8'hC3; pad_valid = 8'hFF;
        settle(3);
        pad_in = 8'h00; pad_valid = 8'h00;
        settle(3); #1;
        chk("R9 all floating hold", rd_data, 8'hC3);
        pad_valid = 8'h0F;
        settle(3); #1;
        chk("R9 partial valid", rd_data, 8'hC0);
        pad_in = 8'hFF; pad_valid = 8'h00;
        settle(3); #1;
        chk("R9 ignores floating pad", rd_data, 8'hC0);

        // serial takeover and return
        reg_write(A_DATA, 8'h00);
        reg_write(A_MODE, 8'h81);
        @(negedge clk);
        spi_en = 1'b1; spi_do = 1'b1; #1;
        chk("R11 takeover oe", pad_oe, 8'hFE);
        chk("R11 takeover o", pad_o, 8'h80);
        @(negedge clk);
        spi_en = 1'b0; #1;
        chk("R12 restore oe", pad_oe, 8'h7E);
        chk("R12 restore o", pad_o, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule